// File: doc/BRIEF.md
# Spread-spectrum modulation profile generator

This block produces the digital frequency-offset profile that a fractional feedback divider follows so that a synthesized clock sweeps around its target frequency. A reference-rate `tick` advances a triangular profile by one phase step. The result is a signed offset word in parts per 100000 of the nominal divider ratio, together with a valid flag. A one-cycle strobe marks each arrival at the minimum-frequency turning point.

Two conventions are available. Center spread swings the offset equally above and below zero, so the average frequency equals the target. Down spread keeps the offset at or below zero, so the peak frequency equals the target and the average sits below it. A 4-bit deviation code sets the swing. A rate select picks one of two half-period lengths, counted in ticks: a slow rate of about 30 kHz and a fast rate of about 120 kHz. Configuration changes take effect only where the offset is zero, so the divider never sees a step.

Top module: `ssm_profile_gen`

## Requirements
- R1: While reset is asserted, and on leaving it, `offset` is 0, `offset_valid` is 0 and `sweep_start` is 0. Reset is asynchronous.
- R2: Spread is requested only when `spread_en` is 1 and `dev_code` is nonzero. Code 0 means spread off: `offset_valid` stays 0 and `offset` stays 0.
- R3: The full swing is S = `dev_code` × 250. With `down_mode` = 0 (center), offset = floor(S·t/H) − S/2, so the offset spans ±`dev_code`×125 and is symmetric about zero.
- R4: With `down_mode` = 1 (down), offset = floor(S·t/H) − S. The offset spans −S to 0 and is never positive.
- R5: The phase t steps once per sampled tick, rising from 0 to H and falling from H back to 0, so one modulation period is 2H ticks. H is `HALF_SLOW` when `fast_rate` = 0 and `HALF_FAST` when it is 1. Outputs change only in the clock cycle after a tick is sampled.
- R6: On the first tick that sees a request while spread is off, `offset_valid` becomes 1 and `offset` is 0. The phase starts at the zero point of the chosen mode (t = H/2 for center, t = H for down) and heads toward the minimum.
- R7: `sweep_start` is high for exactly one cycle, in the cycle after the tick that brings t to 0. At that point `offset` is at its minimum (−S/2 for center, −S for down).
- R8: While spread is active, a change to `spread_en`, `down_mode`, `dev_code` or `fast_rate` is applied only on a tick where the present `offset` is 0. Until then the old profile continues. On that tick the profile restarts at the zero point of the new setting, or turns off.
- R9: Whenever `offset_valid` is 0, `offset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference-rate phase advance, one cycle wide |
| spread_en | input | 1 | Spread request |
| down_mode | input | 1 | 0 = center spread, 1 = down spread |
| dev_code | input | 4 | Deviation code, 125 (center half-swing) or 250 (down swing) parts per 100000 per step |
| fast_rate | input | 1 | 0 = slow modulation rate, 1 = fast modulation rate |
| offset | output | 13 | Signed offset in parts per 100000, registered |
| offset_valid | output | 1 | Profile active |
| sweep_start | output | 1 | One-cycle strobe at the minimum turning point |

## Verification
An error in the phase counter or the remainder accumulator shows as an `offset` that departs from floor(S·t/H) on the very next tick. A slip that goes uncorrected also breaks the exact turning values of the profile within one half period. A wrong turning flag moves or duplicates `sweep_start`, and this is visible one period (2H ticks) later at most. If the active configuration is held wrongly, or the zero-crossing gate is faulty, a reload happens at a nonzero offset, which shows as a jump on the following tick. A stuck gate makes `offset_valid` fall at the wrong tick after `spread_en` is dropped.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  localparam int CODE_W   = 4;
  localparam int SWING_W  = 12;
  localparam int OFS_W    = SWING_W + 1;
  localparam int DEV_STEP = 250;

  typedef struct packed {
    logic              on;
    logic              down;
    logic [CODE_W-1:0] code;
    logic              fast;
  } ssm_cfg_t;

  // full peak-to-peak swing in parts per 100000
  function automatic logic [SWING_W-1:0] swing_of(input logic [CODE_W-1:0] code);
    return SWING_W'(code) * SWING_W'(DEV_STEP);
  endfunction

  // integer part of the per-tick increment
  function automatic logic [SWING_W-1:0] ramp_quot(input logic [SWING_W-1:0] s, input int half);
    return s / SWING_W'(half);
  endfunction

  // fractional remainder of the per-tick increment, in units of 1/half
  function automatic logic [SWING_W-1:0] ramp_rem(input logic [SWING_W-1:0] s, input int half);
    return s % SWING_W'(half);
  endfunction

  // map ramp position to the signed offset word
  function automatic logic signed [OFS_W-1:0] offset_of(input logic [SWING_W-1:0] p,
                                                        input logic [SWING_W-1:0] s,
                                                        input logic down);
    logic signed [OFS_W-1:0] ps;
    logic signed [OFS_W-1:0] base;
    ps   = $signed({1'b0, p});
    base = down ? $signed({1'b0, s}) : $signed({2'b00, s[SWING_W-1:1]});
    return ps - base;
  endfunction

endpackage

// File: rtl/ssm_cfg_track.sv
module ssm_cfg_track
  import ssm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  ssm_cfg_t          req,
  input  logic              ofs_zero,
  output logic              load,
  output ssm_cfg_t          nxt,
  output logic              act_on,
  output logic              act_down,
  output logic [CODE_W-1:0] act_code
);

  ssm_cfg_t act_q;

  // idle: any request loads; active: differences wait for a zero offset
  assign load = tick && (act_q.on ? ((req != act_q) && ofs_zero) : req.on);
  assign nxt  = load ? req : act_q;

  assign act_on   = act_q.on;
  assign act_down = act_q.down;
  assign act_code = act_q.code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= req;
  end

endmodule

// File: rtl/ssm_tri_ramp.sv
module ssm_tri_ramp
  import ssm_pkg::*;
#(
  parameter int HALF_SLOW = 64,
  parameter int HALF_FAST = 16,
  parameter int T_W       = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               on,
  input  logic               down,
  input  logic               fast,
  input  logic [SWING_W-1:0] swing,
  output logic [SWING_W-1:0] pos_nxt,
  output logic               min_evt
);

  logic [T_W-1:0]     t_q, t_d;
  logic [T_W-1:0]     e_q, e_d;
  logic [SWING_W-1:0] p_q, p_d;
  logic               up_q, up_d;
  logic [T_W-1:0]     half;
  logic [SWING_W-1:0] inc_q;
  logic [T_W-1:0]     inc_r;
  logic [T_W:0]       e_sum;

  assign half  = fast ? T_W'(HALF_FAST) : T_W'(HALF_SLOW);
  assign inc_q = fast ? ramp_quot(swing, HALF_FAST) : ramp_quot(swing, HALF_SLOW);
  assign inc_r = T_W'(fast ? ramp_rem(swing, HALF_FAST) : ramp_rem(swing, HALF_SLOW));
  assign e_sum = {1'b0, e_q} + {1'b0, inc_r};

  always_comb begin
    t_d     = t_q;
    e_d     = e_q;
    p_d     = p_q;
    up_d    = up_q;
    min_evt = 1'b0;
    if (load) begin
      if (on) begin
        t_d  = down ? half : (half >> 1);
        p_d  = down ? swing : (swing >> 1);
        e_d  = '0;
        up_d = 1'b0;
      end else begin
        t_d  = '0;
        p_d  = '0;
        e_d  = '0;
        up_d = 1'b0;
      end
    end else if (step) begin
      if (up_q) begin
        if (e_sum >= {1'b0, half}) begin
          e_d = T_W'(e_sum - {1'b0, half});
          p_d = p_q + inc_q + SWING_W'(1);
        end else begin
          e_d = T_W'(e_sum);
          p_d = p_q + inc_q;
        end
        t_d = t_q + T_W'(1);
        if (t_d == half) up_d = 1'b0;
      end else begin
        if (e_q >= inc_r) begin
          e_d = e_q - inc_r;
          p_d = p_q - inc_q;
        end else begin
          e_d = e_q + half - inc_r;
          p_d = p_q - inc_q - SWING_W'(1);
        end
        t_d = t_q - T_W'(1);
        if (t_d == '0) begin
          up_d    = 1'b1;
          min_evt = 1'b1;
        end
      end
    end
  end

  assign pos_nxt = p_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      e_q  <= '0;
      p_q  <= '0;
      up_q <= 1'b0;
    end else begin
      t_q  <= t_d;
      e_q  <= e_d;
      p_q  <= p_d;
      up_q <= up_d;
    end
  end

endmodule

// File: rtl/ssm_out_stage.sv
module ssm_out_stage
  import ssm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    on,
  input  logic                    down,
  input  logic [SWING_W-1:0]      swing,
  input  logic [SWING_W-1:0]      pos_nxt,
  input  logic                    min_evt,
  output logic signed [OFS_W-1:0] offset_q,
  output logic                    valid_q,
  output logic                    start_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      valid_q  <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      offset_q <= on ? offset_of(pos_nxt, swing, down) : '0;
      valid_q  <= on;
      start_q  <= min_evt;
    end
  end

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
  import ssm_pkg::*;
#(
  parameter int HALF_SLOW = 64,
  parameter int HALF_FAST = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    spread_en,
  input  logic                    down_mode,
  input  logic [CODE_W-1:0]       dev_code,
  input  logic                    fast_rate,
  output logic signed [OFS_W-1:0] offset,
  output logic                    offset_valid,
  output logic                    sweep_start
);

  localparam int HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int T_W      = $clog2(HALF_MAX + 1);

  generate
    if ((HALF_SLOW % 2) != 0 || (HALF_FAST % 2) != 0 || HALF_SLOW < 2 || HALF_FAST < 2) begin : g_half_chk
      $error("half-period lengths must be even and at least 2");
    end
  endgenerate

  ssm_cfg_t           req_cfg;
  ssm_cfg_t           nxt_cfg;
  logic               req_on;
  logic               load_evt;
  logic               step_evt;
  logic               min_evt;
  logic               ofs_zero;
  logic               act_on;
  logic               act_down;
  logic [CODE_W-1:0]  act_code;
  logic [SWING_W-1:0] swing_nxt;
  logic [SWING_W-1:0] swing_act;
  logic [SWING_W-1:0] pos_nxt;

  assign req_on    = spread_en && (dev_code != '0);
  assign req_cfg   = req_on ? '{on: 1'b1, down: down_mode, code: dev_code, fast: fast_rate} : '0;
  assign ofs_zero  = (offset == '0);
  assign step_evt  = tick && act_on && !load_evt;
  assign swing_nxt = swing_of(nxt_cfg.code);
  assign swing_act = swing_of(act_code);

  ssm_cfg_track u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .req      (req_cfg),
    .ofs_zero (ofs_zero),
    .load     (load_evt),
    .nxt      (nxt_cfg),
    .act_on   (act_on),
    .act_down (act_down),
    .act_code (act_code)
  );

  ssm_tri_ramp #(
    .HALF_SLOW (HALF_SLOW),
    .HALF_FAST (HALF_FAST),
    .T_W       (T_W)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_evt),
    .step    (step_evt),
    .on      (nxt_cfg.on),
    .down    (nxt_cfg.down),
    .fast    (nxt_cfg.fast),
    .swing   (swing_nxt),
    .pos_nxt (pos_nxt),
    .min_evt (min_evt)
  );

  ssm_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .on       (nxt_cfg.on),
    .down     (nxt_cfg.down),
    .swing    (swing_nxt),
    .pos_nxt  (pos_nxt),
    .min_evt  (min_evt),
    .offset_q (offset),
    .valid_q  (offset_valid),
    .start_q  (sweep_start)
  );

endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk
  import ssm_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic signed [OFS_W-1:0] offset,
  input logic                    offset_valid,
  input logic                    sweep_start,
  input logic                    act_on,
  input logic                    act_down,
  input logic [SWING_W-1:0]      swing,
  input logic                    load_evt
);

  logic signed [OFS_W-1:0] half_s;
  logic signed [OFS_W-1:0] full_s;

  assign full_s = $signed({1'b0, swing});
  assign half_s = $signed({2'b00, swing[SWING_W-1:1]});

  a_r9_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !offset_valid |-> offset == '0);

  a_r4_down_never_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_valid && act_down) |-> offset <= 0);

  a_r3_center_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_valid && !act_down) |-> (offset <= half_s && offset >= -half_s));

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(offset) && $stable(offset_valid)));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> !sweep_start);

  a_r7_strobe_at_minimum: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |-> offset == (act_down ? -full_s : -half_s));

  a_r8_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && act_on) |-> offset == '0);

  a_r6_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !act_on) |=> (offset == '0 && offset_valid));

endmodule

bind ssm_profile_gen ssm_profile_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .offset       (offset),
  .offset_valid (offset_valid),
  .sweep_start  (sweep_start),
  .act_on       (act_on),
  .act_down     (act_down),
  .swing        (swing_act),
  .load_evt     (load_evt)
);

// File: tb/tb_ssm_profile_gen.sv
module tb_ssm_profile_gen;

  localparam int HS = 64;
  localparam int HF = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              spread_en = 1'b0;
  logic              down_mode = 1'b0;
  logic [3:0]        dev_code = 4'd0;
  logic              fast_rate = 1'b0;
  logic signed [12:0] offset;
  logic              offset_valid;
  logic              sweep_start;

  int n_chk = 0;
  int n_err = 0;

  // reference model state, built from the requirements
  bit m_on, m_down, m_fast, m_up, m_strobe;
  int m_code, m_t;

  typedef struct packed {
    logic               down;
    logic [3:0]         code;
    logic               fast;
    logic signed [15:0] lo;
    logic signed [15:0] hi;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b0, 4'd1,  1'b1, -16'sd125,  16'sd125},
    '{1'b0, 4'd15, 1'b0, -16'sd1875, 16'sd1875},
    '{1'b1, 4'd1,  1'b1, -16'sd250,  16'sd0},
    '{1'b1, 4'd15, 1'b0, -16'sd3750, 16'sd0},
    '{1'b0, 4'd6,  1'b1, -16'sd750,  16'sd750},
    '{1'b1, 4'd8,  1'b1, -16'sd2000, 16'sd0}
  };

  ssm_profile_gen #(.HALF_SLOW(HS), .HALF_FAST(HF)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .spread_en    (spread_en),
    .down_mode    (down_mode),
    .dev_code     (dev_code),
    .fast_rate    (fast_rate),
    .offset       (offset),
    .offset_valid (offset_valid),
    .sweep_start  (sweep_start)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_half();
    return m_fast ? HF : HS;
  endfunction

  function automatic int m_ofs();
    int s, p;
    if (!m_on) return 0;
    s = m_code * 250;
    p = (s * m_t) / m_half();
    return m_down ? p - s : p - s / 2;
  endfunction

  task automatic model_tick();
    bit req_on, chg;
    req_on   = spread_en && (dev_code != 0);
    chg      = m_on ? (!req_on || down_mode != m_down || int'(dev_code) != m_code || fast_rate != m_fast)
                    : req_on;
    m_strobe = 1'b0;
    if (chg && (!m_on || m_ofs() == 0)) begin
      m_on = req_on;
      if (req_on) begin
        m_down = down_mode;
        m_code = dev_code;
        m_fast = fast_rate;
        m_t    = m_down ? m_half() : m_half() / 2;
        m_up   = 1'b0;
      end
    end else if (m_on) begin
      if (m_up) begin
        m_t++;
        if (m_t == m_half()) m_up = 1'b0;
      end else begin
        m_t--;
        if (m_t == 0) begin
          m_up     = 1'b1;
          m_strobe = 1'b1;
        end
      end
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    model_tick();
  endtask

  task automatic compare();
    string tg;
    tg = !m_on ? "R9" : (m_down ? "R4" : "R3");
    chk(offset_valid == m_on, "R6 valid", int'(offset_valid), int'(m_on));
    chk(int'(offset) == m_ofs(), tg, int'(offset), m_ofs());
    chk(sweep_start == m_strobe, "R7 strobe", int'(sweep_start), int'(m_strobe));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0;
    spread_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_on = 0; m_down = 0; m_fast = 0; m_up = 0; m_strobe = 0; m_code = 0; m_t = 0;
  endtask

  task automatic start_cfg(input bit dn, input int code, input bit fst);
    down_mode = dn;
    dev_code  = 4'(code);
    fast_rate = fst;
    spread_en = 1'b1;
    do_tick();
    compare();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int lo, hi, nstb, first_stb, gap, cnt, held;
    do_reset();
    // R1: reset state
    chk(offset == 0, "R1 offset", int'(offset), 0);
    chk(offset_valid == 0, "R1 valid", int'(offset_valid), 0);
    chk(sweep_start == 0, "R1 strobe", int'(sweep_start), 0);

    // table of configurations and their expected extremes
    for (int i = 0; i < 6; i++) begin
      int h;
      do_reset();
      start_cfg(VECS[i].down, int'(VECS[i].code), VECS[i].fast);
      chk(offset_valid == 1 && offset == 0, "R6 start at zero", int'(offset), 0);
      h = VECS[i].fast ? HF : HS;
      lo = 0; hi = 0; nstb = 0; first_stb = -1; gap = 0;
      for (int k = 1; k <= 4 * h; k++) begin
        do_tick();
        compare();
        if (int'(offset) < lo) lo = int'(offset);
        if (int'(offset) > hi) hi = int'(offset);
        if (sweep_start) begin
          nstb++;
          if (first_stb < 0) first_stb = k;
          else gap = k - first_stb;
        end
      end
      chk(lo == int'(VECS[i].lo), VECS[i].down ? "R4 minimum" : "R3 minimum", lo, int'(VECS[i].lo));
      chk(hi == int'(VECS[i].hi), VECS[i].down ? "R4 maximum" : "R3 maximum", hi, int'(VECS[i].hi));
      chk(nstb == 2, "R7 strobe count", nstb, 2);
      chk(gap == 2 * h, "R5 period", gap, 2 * h);
    end

    // R2: code 0 and a low enable both leave the profile off
    do_reset();
    spread_en = 1'b1; dev_code = 4'd0;
    for (int k = 0; k < 4; k++) begin
      do_tick();
      chk(offset_valid == 0 && offset == 0, "R2 code zero", int'(offset_valid), 0);
    end
    spread_en = 1'b0; dev_code = 4'd5;
    for (int k = 0; k < 4; k++) begin
      do_tick();
      chk(offset_valid == 0 && offset == 0, "R2 enable low", int'(offset_valid), 0);
    end

    // R5: no change without a tick
    do_reset();
    start_cfg(1'b0, 6, 1'b1);
    repeat (3) begin do_tick(); compare(); end
    held = int'(offset);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(int'(offset) == held, "R5 hold between ticks", int'(offset), held);
    end

    // R8: disable waits for the zero crossing
    do_reset();
    start_cfg(1'b0, 4, 1'b1);
    repeat (3) begin do_tick(); compare(); end
    spread_en = 1'b0;
    cnt = 0;
    while (offset_valid && cnt < 100) begin
      do_tick();
      compare();
      cnt++;
    end
    chk(cnt == 14, "R8 disable at zero", cnt, 14);
    chk(offset == 0, "R9 offset after off", int'(offset), 0);

    // R8: mode change waits for the zero crossing
    do_reset();
    start_cfg(1'b0, 4, 1'b1);
    repeat (3) begin do_tick(); compare(); end
    down_mode = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      do_tick();
      compare();
      if (k == 12) chk(int'(offset) == -63, "R8 old profile kept", int'(offset), -63);
      if (k == 13) chk(int'(offset) == 0, "R8 zero crossing", int'(offset), 0);
      if (k == 14) chk(int'(offset) == 0 && offset_valid, "R8 reload at top", int'(offset), 0);
      if (k == 15) chk(int'(offset) == -63, "R8 new down profile", int'(offset), -63);
    end

    // R1: asynchronous reset while active
    do_reset();
    start_cfg(1'b1, 9, 1'b1);
    repeat (5) begin do_tick(); compare(); end
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk(offset == 0 && offset_valid == 0 && sweep_start == 0, "R1 reset mid-run", int'(offset), 0);
    @(negedge clk) rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule